// File: doc/BRIEF.md
# Rapid Marker Down-Count Decoder

This block sits in the receive path of a link running low-power idle over four forward-error-correction lanes that together carry twenty PCS lanes. Each PCS lane delivers two payload bytes of a rapid alignment marker: a count byte and a lane-identity byte. The block recovers each lane's down-count by XOR-ing the two bytes. It then reports the single down-count seen on the largest number of lanes, because lanes are not yet deskewed and may disagree. It also reports whether each FEC lane carries a trustworthy marker sequence.

Each FEC lane k owns PCS lanes 5k to 5k+4. An FEC lane is judged valid when its upstream sequence-valid flag is set and at least two of its own strobed PCS lanes decode to the same down-count. The aggregate flag combines the four per-FEC-lane judgements and feeds the low-power-idle receive state machine, as does the majority count.

Top module: `rmd_decoder`

## Requirements
- R1: The down-count of a PCS lane is the bitwise XOR of its count byte and its identity byte.
- R2: `down_count` is the value decoded on the largest number of strobed PCS lanes.
- R3: When two or more values share the highest occurrence count, `down_count` takes the numerically lowest of them.
- R4: A PCS lane whose bit in `lane_stb` is low does not vote and does not count towards any pair, whatever its bytes hold.
- R5: `fec_ramps_ok[k]` is 1 only when `seq_ok[k]` is 1 and at least two strobed PCS lanes of FEC lane k decode to the same value.
- R6: FEC lane k owns PCS lanes 5k..5k+4 (bits [8*i+7:8*i] of the byte buses belong to PCS lane i); equal values on lanes of two different FEC lanes do not form a pair.
- R7: Different down-counts on different FEC lanes do not clear any per-FEC-lane flag.
- R8: `ramps_ok` is the AND of the four `fec_ramps_ok` bits.
- R9: All outputs are registered. They take new values at the first rising edge at which any `lane_stb` bit is high and hold otherwise.
- R10: After reset, `down_count` is 0 and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cd_bytes | input | 160 | Count byte per PCS lane, lane i in bits [8i+7:8i] |
| id_bytes | input | 160 | Identity byte per PCS lane, same layout |
| lane_stb | input | 20 | Payload-valid strobe per PCS lane |
| seq_ok | input | 4 | Payload-sequence-valid flag per FEC lane |
| down_count | output | 8 | Majority down-count |
| fec_ramps_ok | output | 4 | Per-FEC-lane validity |
| ramps_ok | output | 1 | AND of the per-FEC-lane validity flags |

## Verification
Every result is due exactly one rising edge after the cycle in which the strobe and bytes are presented. The bench drives on the falling edge and reads all outputs on the next falling edge, after one register stage. It also reads the outputs right after driving, before that edge, to confirm they still hold the previous result. Cycles with no strobe are followed by reads several edges later, which must show the old values.

// File: rtl/rmd_pkg.sv
package rmd_pkg;
  localparam int CW = 8;
  typedef logic [CW-1:0] dcount_t;
endpackage

// File: rtl/rmd_lane_xor.sv
module rmd_lane_xor
  import rmd_pkg::*;
#(
  parameter int LANES = 20
) (
  input  logic [LANES*CW-1:0]   cd_bytes,
  input  logic [LANES*CW-1:0]   id_bytes,
  output logic [LANES-1:0][CW-1:0] lane_val
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_val[i] = cd_bytes[i*CW +: CW] ^ id_bytes[i*CW +: CW];
  end
endmodule

// File: rtl/rmd_pair_detect.sv
module rmd_pair_detect
  import rmd_pkg::*;
#(
  parameter int GRP = 5
) (
  input  logic [GRP-1:0][CW-1:0] val,
  input  logic [GRP-1:0]         vld,
  output logic                   pair_found
);
  always_comb begin
    pair_found = 1'b0;
    for (int i = 0; i < GRP; i++) begin
      for (int j = i + 1; j < GRP; j++) begin
        if (vld[i] && vld[j] && (val[i] == val[j])) pair_found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rmd_mode_vote.sv
module rmd_mode_vote
  import rmd_pkg::*;
#(
  parameter int LANES = 20
) (
  input  logic [LANES-1:0][CW-1:0] val,
  input  logic [LANES-1:0]         vld,
  output logic [CW-1:0]            mode_val
);
  localparam int NW = $clog2(LANES + 1);

  logic [LANES-1:0][NW-1:0] hits;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      hits[i] = '0;
      for (int j = 0; j < LANES; j++) begin
        if (vld[j] && (val[j] == val[i])) hits[i] = hits[i] + NW'(1);
      end
    end
  end

  logic [NW-1:0] best_hits;
  always_comb begin
    best_hits = '0;
    mode_val  = '1;
    for (int i = 0; i < LANES; i++) begin
      if (vld[i]) begin
        if ((hits[i] > best_hits) ||
            ((hits[i] == best_hits) && (val[i] < mode_val))) begin
          best_hits = hits[i];
          mode_val  = val[i];
        end
      end
    end
  end
endmodule

// File: rtl/rmd_decoder.sv
module rmd_decoder
  import rmd_pkg::*;
#(
  parameter int NUM_FEC     = 4,
  parameter int PCS_PER_FEC = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_FEC*PCS_PER_FEC*CW-1:0] cd_bytes,
  input  logic [NUM_FEC*PCS_PER_FEC*CW-1:0] id_bytes,
  input  logic [NUM_FEC*PCS_PER_FEC-1:0]  lane_stb,
  input  logic [NUM_FEC-1:0]              seq_ok,
  output logic [CW-1:0]                   down_count,
  output logic [NUM_FEC-1:0]              fec_ramps_ok,
  output logic                            ramps_ok
);
  localparam int LANES = NUM_FEC * PCS_PER_FEC;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  logic [LANES-1:0][CW-1:0] lane_val;

  rmd_lane_xor #(.LANES(LANES)) u_xor (
    .cd_bytes (cd_bytes),
    .id_bytes (id_bytes),
    .lane_val (lane_val)
  );

  logic [CW-1:0] mode_d;
  rmd_mode_vote #(.LANES(LANES)) u_vote (
    .val      (lane_val),
    .vld      (lane_stb),
    .mode_val (mode_d)
  );

  logic [NUM_FEC-1:0] pair_d;
  for (genvar k = 0; k < NUM_FEC; k++) begin : g_fec
    rmd_pair_detect #(.GRP(PCS_PER_FEC)) u_pair (
      .val        (lane_val[k*PCS_PER_FEC +: PCS_PER_FEC]),
      .vld        (lane_stb[k*PCS_PER_FEC +: PCS_PER_FEC]),
      .pair_found (pair_d[k])
    );
  end

  // next-state
  logic               upd_en;
  logic [NUM_FEC-1:0] fec_d;
  logic               all_d;
  always_comb begin
    upd_en = |lane_stb;
    fec_d  = pair_d & seq_ok;
    all_d  = &fec_d;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      down_count   <= '0;
      fec_ramps_ok <= '0;
      ramps_ok     <= 1'b0;
    end else if (upd_en) begin
      down_count   <= mode_d;
      fec_ramps_ok <= fec_d;
      ramps_ok     <= all_d;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    !(|lane_stb) |=> ($stable(down_count) && $stable(fec_ramps_ok) && $stable(ramps_ok)));

  p_agg_and_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    ramps_ok == (&fec_ramps_ok));

  p_lone_voter_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    ($countones(lane_stb) == 1) |=> (fec_ramps_ok == '0));

  for (genvar k = 0; k < NUM_FEC; k++) begin : g_chk
    p_seq_gate_r5: assert property (@(posedge clk) disable iff (!rst_ok)
      ((|lane_stb) && !seq_ok[k]) |=> !fec_ramps_ok[k]);
  end
endmodule

// File: tb/rmd_decoder_tb_top.sv
module rmd_decoder_tb_top;
  localparam int L = 20;
  localparam int F = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [L*8-1:0] cd_bytes, id_bytes;
  logic [L-1:0]  lane_stb;
  logic [F-1:0]  seq_ok;
  logic [7:0]    down_count;
  logic [F-1:0]  fec_ramps_ok;
  logic          ramps_ok;

  always #2.5 clk = ~clk;

  rmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cd_bytes(cd_bytes), .id_bytes(id_bytes),
    .lane_stb(lane_stb), .seq_ok(seq_ok), .down_count(down_count),
    .fec_ramps_ok(fec_ramps_ok), .ramps_ok(ramps_ok)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] vals [L];
  logic [L-1:0] stb_m;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference: histogram, highest count, lowest value on tie
  function automatic logic [7:0] ref_mode();
    int hist [256];
    int best = 0;
    logic [7:0] bv = 8'd0;
    for (int v = 0; v < 256; v++) hist[v] = 0;
    for (int i = 0; i < L; i++) if (stb_m[i]) hist[vals[i]]++;
    for (int v = 0; v < 256; v++)
      if (hist[v] > best) begin best = hist[v]; bv = 8'(v); end
    return bv;
  endfunction

  function automatic logic [F-1:0] ref_fec(logic [F-1:0] sq);
    logic [F-1:0] r = '0;
    for (int k = 0; k < F; k++)
      for (int i = 5*k; i < 5*k+5; i++)
        for (int j = i+1; j < 5*k+5; j++)
          if (stb_m[i] && stb_m[j] && vals[i] == vals[j] && sq[k]) r[k] = 1'b1;
    return r;
  endfunction

  task automatic drive(logic [F-1:0] sq);
    for (int i = 0; i < L; i++) begin
      logic [7:0] c = 8'($urandom);
      cd_bytes[i*8 +: 8] = c;
      id_bytes[i*8 +: 8] = c ^ vals[i];
    end
    lane_stb = stb_m;
    seq_ok   = sq;
  endtask

  logic [7:0] pm; logic [F-1:0] pf; logic pr;

  // present one set, confirm old values hold before the edge, check after
  task automatic run(string req, logic [F-1:0] sq);
    logic [7:0] em; logic [F-1:0] ef;
    @(negedge clk);
    pm = down_count; pf = fec_ramps_ok; pr = ramps_ok;
    drive(sq);
    #0.5;
    check({req, " R9 pre-edge"}, 32'(down_count), 32'(pm));
    em = ref_mode();
    ef = ref_fec(sq);
    @(negedge clk);
    check({req, " R2 mode"},   32'(down_count),   32'(em));
    check({req, " R5 fec"},    32'(fec_ramps_ok), 32'(ef));
    check({req, " R8 all"},    32'(ramps_ok),     32'(&ef));
    lane_stb = '0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; lane_stb = '0; seq_ok = '0; cd_bytes = '0; id_bytes = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 count", 32'(down_count), 32'd0);
    check("R10 flags", 32'({fec_ramps_ok, ramps_ok}), 32'd0);

    // R1: all lanes decode to 5 with random byte pairs
    for (int i = 0; i < L; i++) vals[i] = 8'd5;
    stb_m = '1;
    run("R1 uniform", 4'hF);
    check("R1 value", 32'(down_count), 32'd5);

    // R3: tie 10 votes each for 9 and 3
    for (int i = 0; i < L; i++) vals[i] = (i < 10) ? 8'd9 : 8'd3;
    run("R3 tie", 4'hF);
    check("R3 lowest", 32'(down_count), 32'd3);

    // R6: pair straddles lanes 4 and 5 only
    for (int i = 0; i < L; i++) vals[i] = (i < 10) ? 8'(40 + i) : 8'd1;
    vals[5] = vals[4];
    run("R6 boundary", 4'hF);
    check("R6 flags", 32'(fec_ramps_ok), 32'b1100);

    // R7: each FEC lane carries its own value
    for (int i = 0; i < L; i++) vals[i] = 8'(10 + i/5);
    run("R7 differ", 4'hF);
    check("R7 flags", 32'(fec_ramps_ok), 32'hF);
    check("R7 tie low", 32'(down_count), 32'd10);

    // R4: only lanes 0,1 strobed; others carry a majority that must not count
    for (int i = 0; i < L; i++) vals[i] = (i < 2) ? 8'd7 : 8'd2;
    stb_m = 20'h3;
    run("R4 masked", 4'hF);
    check("R4 mode", 32'(down_count), 32'd7);
    check("R4 flags", 32'(fec_ramps_ok), 32'b0001);

    // R5: sequence flag low on FEC lane 2
    for (int i = 0; i < L; i++) vals[i] = 8'd33;
    stb_m = '1;
    run("R5 seq", 4'b1011);
    check("R5 gated", 32'({fec_ramps_ok, ramps_ok}), 32'b10110);

    // R9: no strobe -> outputs hold
    pm = down_count; pf = fec_ramps_ok; pr = ramps_ok;
    @(negedge clk);
    for (int i = 0; i < L; i++) vals[i] = 8'd99;
    stb_m = '0;
    drive(4'h0);
    repeat (3) @(negedge clk);
    check("R9 hold count", 32'(down_count), 32'(pm));
    check("R9 hold flags", 32'({fec_ramps_ok, ramps_ok}), 32'({pf, pr}));

    // random mix with small value alphabet
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < L; i++) vals[i] = 8'($urandom_range(0, 5) * 37);
      stb_m = 20'($urandom);
      if (stb_m == '0) stb_m[n % L] = 1'b1;
      run("R2 random", 4'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule